// File: doc/BRIEF.md
# Multiplexed External Memory Bus Interface

This block turns word-wide read and write requests from an internal bus into external memory cycles on a shared set of sixteen address/data pins. It has a dedicated low address bus and four upper address lines. A two-bit configuration picks the bus width (8 or 16 bits) and whether the address and data share the same pins (multiplexed) or not (demultiplexed). Each external cycle has a fixed address phase and a fixed data phase. In multiplexed modes an address latch enable strobe tells the outside world when to capture the address.

The internal address is 24 bits wide. Only its low 20 bits leave the block. In 8-bit modes every word access becomes two external cycles. The low byte goes first at the even address, and the high byte follows at the odd address. Read bytes are gathered into one word before completion is signalled.

When no external cycle is in progress, the shared pins do not float. The sixteen AD pins drive a general-purpose port value, and the four upper address lines drive a second port value.

Top module: `ebi_top`

## Requirements
- R1: While reset is held and in the first idle cycle after it, the block is in this state: `req_ready`=1, `req_done`=0, `ext_last`=0, `ale`=0, `req_rdata`=0, `ad_oe` all ones, `ad_out`=`ad_port` and `ahi_out`=`ahi_port`.
- R2: A request is taken at a rising edge where `req_ready` and `req_valid` are both high. The mode (`cfg_wide`, `cfg_mux`), direction, address and write data are captured at that edge. Later changes to these inputs, including a new `req_valid` while busy, have no effect until `req_ready` returns.
- R3: An external cycle lasts 4 clocks: 2 address-phase clocks followed by 2 data-phase clocks. `ext_last` is high on the 4th clock only.
- R4: In multiplexed modes `ale` is high on the first clock of every external cycle and low otherwise. In demultiplexed modes `ale` stays low.
- R5: For the whole of an external cycle, `a_out` carries external address bits 15:0 and `ahi_out` carries bits 19:16. Request address bits 23:20 are dropped.
- R6: In 16-bit multiplexed mode (`cfg_wide`=1, `cfg_mux`=1), all AD pins drive address bits 15:0 during the address phase. During the data phase they drive the write word, or they float on a read.
- R7: In 8-bit multiplexed mode (`cfg_wide`=0, `cfg_mux`=1), AD15:8 drive address bits 15:8 for the whole cycle. AD7:0 drive address bits 7:0 during the address phase. During the data phase AD7:0 drive the write byte, or they float on a read.
- R8: In 16-bit demultiplexed mode (`cfg_wide`=1, `cfg_mux`=0), AD15:0 drive the write word for the whole cycle on a write, and they float for the whole cycle on a read.
- R9: In 8-bit demultiplexed mode (`cfg_wide`=0, `cfg_mux`=0), AD7:0 drive the write byte for the whole cycle on a write and float on a read. AD15:8 are always driven with the high byte of the internal data register. That register holds the captured write word on a write and zero on a read.
- R10: Read data is sampled from `ad_in` only at the edge that ends the last data-phase clock. Values present on other clocks are ignored.
- R11: In 8-bit modes a request becomes two external cycles. The first cycle uses the address with bit 0 cleared and carries the low byte. The second cycle uses the address with bit 0 set and carries the high byte. In 8-bit mode only `ad_in[7:0]` is used.
- R12: `req_done` pulses for one clock, on the clock after the last external cycle. On a read, `req_rdata` then holds the assembled word. A write leaves `req_rdata` unchanged. `req_ready` returns on the following clock.
- R13: Whenever no external cycle is in progress, `ad_oe` is all ones, `ad_out` equals `ad_port`, `ahi_out` equals `ahi_port`, and `ale` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| cfg_mux | input | 1 | 1 = address and data multiplexed on AD pins |
| req_valid | input | 1 | Internal request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Internal byte address |
| req_wdata | input | 16 | Internal write word |
| req_ready | output | 1 | Block idle and able to take a request |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Assembled read word |
| ext_last | output | 1 | Last clock of an external cycle |
| ad_port | input | 16 | Port value shown on AD pins while idle |
| ahi_port | input | 4 | Port value shown on upper address lines while idle |
| a_out | output | 16 | External address bits 15:0 |
| ahi_out | output | 4 | Address bits 19:16 or port value |
| ad_out | output | 16 | AD pin output values |
| ad_oe | output | 16 | Per-pin output enable for AD pins |
| ad_in | input | 16 | AD pin input values |
| ale | output | 1 | Address latch enable strobe |

## Verification
The bench builds the block with its default parameters: a 24-bit internal address, 20 external address lines, a 16-bit data bus and a 2+2 clock cycle. These values are small enough to check every clock of every external cycle against values computed in the bench. The bench sweeps all four modes, both directions, and a set of addresses that includes odd ones and ones with nonzero bits above bit 19. While the block is busy, the bench drives inverted request and configuration inputs and the bitwise complement of the read data on every clock except the sampling clock. This exposes any logic that fails to latch its inputs or that samples at the wrong time.

// File: rtl/ebi_pkg.sv
// Shared types for the external bus interface.
package ebi_pkg;
    // Top-level sequencer state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_DONE = 2'd2
    } ebi_state_t;

    // Bus mode captured per request.
    typedef struct packed {
        logic wide;   // 1: 16-bit bus, 0: 8-bit bus
        logic muxed;  // 1: address and data share the AD pins
    } ebi_mode_t;
endpackage

// File: rtl/ebi_seq.sv
// Request sequencer: takes one word request when idle, latches it, and
// steps through one (16-bit) or two (8-bit) external cycles of
// ADDR_CLKS + DATA_CLKS clocks each, then pulses completion.
// Assumes ADDR_CLKS >= 1, DATA_CLKS >= 1 and EADDR_W > DATA_W.
module ebi_seq
    import ebi_pkg::*;
#(
    parameter int EADDR_W   = 20,
    parameter int DATA_W    = 16,
    parameter int ADDR_CLKS = 2,
    parameter int DATA_CLKS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wide,
    input  logic               cfg_mux,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [EADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               req_done,
    output logic               bus_act,
    output logic               addr_ph,
    output logic               first_clk,
    output logic               last_clk,
    output logic               byte_sel,
    output logic               wr_q,
    output ebi_mode_t          mode_q,
    output logic [EADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0]  dreg
);
    localparam int CYC  = ADDR_CLKS + DATA_CLKS;
    localparam int PH_W = (CYC > 2) ? $clog2(CYC) : 1;
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(CYC - 1);
    localparam logic [PH_W-1:0] PH_DATA0 = PH_W'(ADDR_CLKS);

    ebi_state_t         state;
    logic [PH_W-1:0]    ph;
    logic [EADDR_W-1:0] addr_q;

    // Advance state, phase and byte counters; latch the request on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ph       <= '0;
            byte_sel <= 1'b0;
            wr_q     <= 1'b0;
            mode_q   <= '0;
            addr_q   <= '0;
            dreg     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state    <= ST_BUS;
                        ph       <= '0;
                        byte_sel <= 1'b0;
                        wr_q     <= req_write;
                        mode_q   <= '{wide: cfg_wide, muxed: cfg_mux};
                        addr_q   <= req_addr;
                        dreg     <= req_write ? req_wdata : '0;
                    end
                end
                ST_BUS: begin
                    if (ph == PH_LAST) begin
                        ph <= '0;
                        if (!mode_q.wide && !byte_sel) begin
                            byte_sel <= 1'b1;
                        end else begin
                            state <= ST_DONE;
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: begin
                    state    <= ST_IDLE;
                    byte_sel <= 1'b0;
                end
            endcase
        end
    end

    // Decode the phase counter into strobes for the pin and capture logic.
    always_comb begin
        req_ready = (state == ST_IDLE);
        req_done  = (state == ST_DONE);
        bus_act   = (state == ST_BUS);
        addr_ph   = bus_act && (ph < PH_DATA0);
        first_clk = bus_act && (ph == '0);
        last_clk  = bus_act && (ph == PH_LAST);
    end

    // Form the external address: byte lanes split the word in 8-bit mode.
    always_comb begin
        if (mode_q.wide) begin
            ext_addr = addr_q;
        end else begin
            ext_addr = {addr_q[EADDR_W-1:1], byte_sel};
        end
    end
endmodule

// File: rtl/ebi_pinmux.sv
// Pin multiplexer: decides per mode and per phase what each AD pin,
// the upper address lines and the latch strobe carry. Purely
// combinational; assumes DATA_W is even and EADDR_W > DATA_W.
module ebi_pinmux
    import ebi_pkg::*;
#(
    parameter int EADDR_W = 20,
    parameter int DATA_W  = 16
) (
    input  logic                       bus_act,
    input  logic                       addr_ph,
    input  logic                       first_clk,
    input  logic                       wr_q,
    input  logic                       byte_sel,
    input  ebi_mode_t                  mode_q,
    input  logic [EADDR_W-1:0]         ext_addr,
    input  logic [DATA_W-1:0]          dreg,
    input  logic [DATA_W-1:0]          ad_port,
    input  logic [EADDR_W-DATA_W-1:0]  ahi_port,
    output logic [DATA_W-1:0]          a_out,
    output logic [EADDR_W-DATA_W-1:0]  ahi_out,
    output logic [DATA_W-1:0]          ad_out,
    output logic [DATA_W-1:0]          ad_oe,
    output logic                       ale
);
    localparam int BW = DATA_W / 2;

    logic [BW-1:0] byte_data;

    // Pick the byte of the latched word that the current 8-bit cycle moves.
    always_comb byte_data = byte_sel ? dreg[DATA_W-1:BW] : dreg[BW-1:0];

    // Dedicated low address bus follows the external address.
    always_comb a_out = ext_addr[DATA_W-1:0];

    // Route AD pins, upper address lines and strobe by mode and phase.
    always_comb begin
        ad_out  = ad_port;
        ad_oe   = '1;
        ahi_out = ahi_port;
        ale     = 1'b0;
        if (bus_act) begin
            ahi_out = ext_addr[EADDR_W-1:DATA_W];
            ale     = first_clk && mode_q.muxed;
            case ({mode_q.wide, mode_q.muxed})
                2'b11: begin
                    if (addr_ph) begin
                        ad_out = ext_addr[DATA_W-1:0];
                        ad_oe  = '1;
                    end else begin
                        ad_out = dreg;
                        ad_oe  = {DATA_W{wr_q}};
                    end
                end
                2'b01: begin
                    ad_out[DATA_W-1:BW] = ext_addr[DATA_W-1:BW];
                    ad_oe[DATA_W-1:BW]  = '1;
                    if (addr_ph) begin
                        ad_out[BW-1:0] = ext_addr[BW-1:0];
                        ad_oe[BW-1:0]  = '1;
                    end else begin
                        ad_out[BW-1:0] = byte_data;
                        ad_oe[BW-1:0]  = {BW{wr_q}};
                    end
                end
                2'b10: begin
                    ad_out = dreg;
                    ad_oe  = {DATA_W{wr_q}};
                end
                default: begin
                    ad_out[DATA_W-1:BW] = dreg[DATA_W-1:BW];
                    ad_oe[DATA_W-1:BW]  = '1;
                    ad_out[BW-1:0]      = byte_data;
                    ad_oe[BW-1:0]       = {BW{wr_q}};
                end
            endcase
        end
    end
endmodule

// File: rtl/ebi_rdcap.sv
// Read assembler: samples the AD pins on the last clock of a read cycle
// and places the value in the word lane the cycle belongs to. Holds its
// value across writes and idle time.
module ebi_rdcap #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              wide,
    input  logic              byte_sel,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata
);
    localparam int BW = DATA_W / 2;

    // Capture the whole word or one byte lane at the sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            if (wide) begin
                rdata <= ad_in;
            end else if (byte_sel) begin
                rdata[DATA_W-1:BW] <= ad_in[BW-1:0];
            end else begin
                rdata[BW-1:0] <= ad_in[BW-1:0];
            end
        end
    end
endmodule

// File: rtl/ebi_top.sv
// External bus interface top: joins the sequencer, pin multiplexer and
// read assembler. Only the low EADDR_W bits of the internal address
// reach the pins; the rest are dropped.
module ebi_top
    import ebi_pkg::*;
#(
    parameter int IADDR_W   = 24,
    parameter int EADDR_W   = 20,
    parameter int DATA_W    = 16,
    parameter int ADDR_CLKS = 2,
    parameter int DATA_CLKS = 2,
    localparam int HI_W     = EADDR_W - DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wide,
    input  logic               cfg_mux,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [IADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               req_done,
    output logic [DATA_W-1:0]  req_rdata,
    output logic               ext_last,
    input  logic [DATA_W-1:0]  ad_port,
    input  logic [HI_W-1:0]    ahi_port,
    output logic [DATA_W-1:0]  a_out,
    output logic [HI_W-1:0]    ahi_out,
    output logic [DATA_W-1:0]  ad_out,
    output logic [DATA_W-1:0]  ad_oe,
    input  logic [DATA_W-1:0]  ad_in,
    output logic               ale
);
    logic               bus_act;
    logic               addr_ph;
    logic               first_clk;
    logic               byte_sel;
    logic               wr_q;
    ebi_mode_t          mode_q;
    logic [EADDR_W-1:0] ext_addr;
    logic [DATA_W-1:0]  dreg;
    logic               unused_addr_hi;

    // Address bits above the external space are not bonded out.
    assign unused_addr_hi = ^req_addr[IADDR_W-1:EADDR_W];

    ebi_seq #(
        .EADDR_W  (EADDR_W),
        .DATA_W   (DATA_W),
        .ADDR_CLKS(ADDR_CLKS),
        .DATA_CLKS(DATA_CLKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wide (cfg_wide),
        .cfg_mux  (cfg_mux),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr[EADDR_W-1:0]),
        .req_wdata(req_wdata),
        .req_ready(req_ready),
        .req_done (req_done),
        .bus_act  (bus_act),
        .addr_ph  (addr_ph),
        .first_clk(first_clk),
        .last_clk (ext_last),
        .byte_sel (byte_sel),
        .wr_q     (wr_q),
        .mode_q   (mode_q),
        .ext_addr (ext_addr),
        .dreg     (dreg)
    );

    ebi_pinmux #(
        .EADDR_W(EADDR_W),
        .DATA_W (DATA_W)
    ) u_pinmux (
        .bus_act  (bus_act),
        .addr_ph  (addr_ph),
        .first_clk(first_clk),
        .wr_q     (wr_q),
        .byte_sel (byte_sel),
        .mode_q   (mode_q),
        .ext_addr (ext_addr),
        .dreg     (dreg),
        .ad_port  (ad_port),
        .ahi_port (ahi_port),
        .a_out    (a_out),
        .ahi_out  (ahi_out),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .ale      (ale)
    );

    ebi_rdcap #(
        .DATA_W(DATA_W)
    ) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (ext_last && !wr_q),
        .wide    (mode_q.wide),
        .byte_sel(byte_sel),
        .ad_in   (ad_in),
        .rdata   (req_rdata)
    );
endmodule

// File: rtl/ebi_checker.sv
// Protocol checker for ebi_top, attached by bind. Observes ports and the
// sequencer's phase outputs; drives nothing.
module ebi_checker #(
    parameter int EADDR_W = 20,
    parameter int DATA_W  = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic                      req_done,
    input logic                      ext_last,
    input logic                      ale,
    input logic                      bus_act,
    input logic                      addr_ph,
    input logic                      wr_q,
    input logic [DATA_W-1:0]         a_out,
    input logic [EADDR_W-DATA_W-1:0] ahi_out,
    input logic [EADDR_W-DATA_W-1:0] ahi_port,
    input logic [DATA_W-1:0]         ad_out,
    input logic [DATA_W-1:0]         ad_oe,
    input logic [DATA_W-1:0]         ad_port
);
    localparam int BW = DATA_W / 2;

    // R4: the latch strobe never lasts beyond one clock.
    a_r4_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R3: the last-clock marker is a single-clock pulse.
    a_r3_last_single: assert property (@(posedge clk) disable iff (!rst_n)
        ext_last |=> !ext_last);

    // R2: an accepted request starts a bus cycle on the next clock.
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (bus_act && !req_ready));

    // R10: read data lanes float during the data phase.
    a_r10_read_float: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_act && !addr_ph && !wr_q) |-> (ad_oe[BW-1:0] == '0));

    // R13: idle pins carry the port values.
    a_r13_idle_port: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_act |-> (ad_oe == '1 && ad_out == ad_port &&
                      ahi_out == ahi_port && !ale));

    // R12: completion follows the last external clock and lasts one clock.
    a_r12_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> $past(ext_last));
    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> (!req_done && req_ready));

    // R5: address lines hold steady within an external cycle.
    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_act && $past(bus_act) && !$past(ext_last)) |->
            ($stable(a_out) && $stable(ahi_out)));
endmodule

bind ebi_top ebi_checker #(
    .EADDR_W(EADDR_W),
    .DATA_W (DATA_W)
) u_ebi_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_done (req_done),
    .ext_last (ext_last),
    .ale      (ale),
    .bus_act  (bus_act),
    .addr_ph  (addr_ph),
    .wr_q     (wr_q),
    .a_out    (a_out),
    .ahi_out  (ahi_out),
    .ahi_port (ahi_port),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .ad_port  (ad_port)
);

// File: tb/ebi_top_bench.sv
// Sweeps every mode, direction and a set of addresses, checking each
// clock of each external cycle against values computed here.
module ebi_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b0, cfg_mux = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, req_done, ext_last, ale;
    logic [15:0] req_rdata, a_out, ad_out, ad_oe;
    logic [15:0] ad_port = 16'h1234;
    logic [3:0]  ahi_port = 4'h9;
    logic [3:0]  ahi_out;
    logic [15:0] ad_in = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [15:0] exp_rdata = '0;

    always #10 clk = ~clk;

    ebi_top u_ebi_top (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_mux(cfg_mux),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .req_done(req_done),
        .req_rdata(req_rdata), .ext_last(ext_last), .ad_port(ad_port),
        .ahi_port(ahi_port), .a_out(a_out), .ahi_out(ahi_out),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Idle pin state (R13, also R1 at reset).
    task automatic chk_idle(input string req);
        chk(ad_oe == 16'hFFFF, req, "ad_oe idle", ad_oe, 16'hFFFF);
        chk(ad_out == ad_port, req, "ad_out idle", ad_out, ad_port);
        chk(ahi_out == ahi_port, req, "ahi_out idle", ahi_out, ahi_port);
        chk(ale == 1'b0, req, "ale idle", ale, 0);
    endtask

    task automatic run_access(input bit wide, input bit mux, input bit wr,
                              input logic [23:0] addr, input logic [15:0] wd,
                              input logic [15:0] rw, input logic [15:0] port,
                              input logic [3:0] hport);
        string mtag;
        int nb;
        logic [19:0] ea;
        logic [15:0] e_oe, e_out, drv;
        logic [7:0]  dbyte;
        mtag = wide ? (mux ? "R6" : "R8") : (mux ? "R7" : "R9");
        nb = wide ? 1 : 2;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
        cfg_wide = wide; cfg_mux = mux; req_write = wr;
        req_addr = addr; req_wdata = wd; req_valid = 1'b1;
        ad_port = port; ahi_port = hport;
        for (int b = 0; b < nb; b++) begin
            for (int p = 0; p < 4; p++) begin
                @(negedge clk);
                ea = wide ? addr[19:0] : {addr[19:1], b[0]};
                dbyte = (b == 1) ? wd[15:8] : wd[7:0];
                if (wide && mux) begin
                    if (p < 2) begin e_oe = 16'hFFFF; e_out = ea[15:0]; end
                    else begin e_oe = wr ? 16'hFFFF : 16'h0000; e_out = wd; end
                end else if (!wide && mux) begin
                    e_oe[15:8] = 8'hFF; e_out[15:8] = ea[15:8];
                    if (p < 2) begin e_oe[7:0] = 8'hFF; e_out[7:0] = ea[7:0]; end
                    else begin e_oe[7:0] = wr ? 8'hFF : 8'h00; e_out[7:0] = dbyte; end
                end else if (wide) begin
                    e_oe = wr ? 16'hFFFF : 16'h0000; e_out = wd;
                end else begin
                    e_oe[15:8] = 8'hFF; e_out[15:8] = wr ? wd[15:8] : 8'h00;
                    e_oe[7:0] = wr ? 8'hFF : 8'h00; e_out[7:0] = dbyte;
                end
                chk(ad_oe == e_oe, mtag, "ad_oe", ad_oe, e_oe);
                if (!wr && p >= 2)
                    chk(ad_oe[7:0] == 8'h00, "R10", "read lane float", ad_oe, 0);
                chk((ad_out & e_oe) == (e_out & e_oe), mtag, "ad_out", ad_out, e_out);
                chk(a_out == ea[15:0], wide ? "R5" : "R11", "a_out", a_out, ea[15:0]);
                chk(ahi_out == ea[19:16], "R5", "ahi_out", ahi_out, ea[19:16]);
                chk(ale == (mux && p == 0), "R4", "ale", ale, (mux && p == 0));
                chk(ext_last == (p == 3), "R3", "ext_last", ext_last, (p == 3));
                chk(req_done == 1'b0, "R12", "done early", req_done, 0);
                chk(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
                // Scramble request and config while busy (R2).
                cfg_wide = ~wide; cfg_mux = ~mux; req_write = ~wr;
                req_addr = ~addr; req_wdata = ~wd; req_valid = 1'b1;
                drv = wide ? rw : {8'hA5, (b == 1) ? rw[15:8] : rw[7:0]};
                ad_in = (p == 3) ? drv : ~drv;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (!wr) exp_rdata = rw;
        chk(req_done == 1'b1, "R12", "done pulse", req_done, 1);
        chk(ext_last == 1'b0, "R3", "last after cycle", ext_last, 0);
        chk(req_rdata == exp_rdata, wr ? "R12" : (wide ? "R10" : "R11"),
            "rdata", req_rdata, exp_rdata);
        chk_idle("R13");
        @(negedge clk);
        chk(req_done == 1'b0, "R12", "done single", req_done, 0);
        chk(req_ready == 1'b1, "R12", "ready back", req_ready, 1);
        chk_idle("R13");
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state under reset.
        chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
        chk(req_done == 1'b0, "R1", "done", req_done, 0);
        chk(ext_last == 1'b0, "R1", "last", ext_last, 0);
        chk(req_rdata == 16'h0, "R1", "rdata", req_rdata, 0);
        chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk_idle("R1");
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [23:0] a;
                    logic [15:0] wd, rw, pt;
                    a  = (24'h3C_2457 * (k + 1)) ^ {m[1:0], w[0], 21'h0};
                    wd = (16'h1357 * (k + 3)) ^ {m[1:0], w[0], 13'h0A5};
                    rw = (16'h2469 * (k + 5)) ^ {m[1:0], 14'h0};
                    pt = 16'hBEEF ^ (16'h0F0F * k);
                    run_access(m[1], m[0], w[0], a, wd, rw, pt, 4'(k + m));
                end
            end
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule